// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the START condition for a bus master on a two-wire serial bus. Software sets a start-enable bit in a small command register. The block then checks that both bus lines are idle-high and runs two timed phases, each paced by a reloadable down-counter. At the end of the first phase it pulls the data line low while the clock line stays released; this is the START condition. At the end of the second phase it clears the start-enable bit, raises a completion flag and keeps the data line held low for the stage that follows.

The start is abandoned if a bus line is found low at the wrong moment. A collision flag is raised, both line drivers are released and the block returns to idle. While a start is in progress the command bits are locked and the transmit buffer ignores writes, so no second operation can be queued. Such a write raises a write-collision flag. Both bus inputs pass through a two-flop synchronizer before any decision uses them. The whole block runs on one clock with a synchronous active-high reset.

The transmit buffer write port is valid/ready. `tx_ready` is held high at all times, so there is never back-pressure. A beat offered while a start is in progress is still consumed, but it is discarded and flagged, not stored.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, `cmd_q` is 0, `tx_buf` is 0, all four status flags are 0, neither drive enable is asserted and `tx_ready` is 1.
- R2: Let E0 be the clock edge that captures a control write with bit 0 (start enable) set, while both synchronized lines read high. With reload value R, `sda_drive_low` rises at edge E0+R+2. Each timed phase lasts R+1 cycles.
- R3: `start_seen` is set on the same edge on which `sda_drive_low` rises.
- R4: At edge E0+2R+3, bit 0 of `cmd_q` clears and `done_irq` is set. `sda_drive_low` stays asserted, and `scl_drive_low` is never asserted.
- R5: The lines are checked on the edge after E0. If either synchronized line reads low there, `bus_coll` is set and `cmd_q` bit 0 clears on that edge (E0+1). SDA is never driven.
- R6: During the first phase, a low synchronized SCL aborts the start on the next edge. A low synchronized SDA at the first timeout also aborts it. An abort sets `bus_coll`, clears `cmd_q` bit 0 and leaves both drive enables released.
- R7: A transmit beat (`tx_valid`) offered while `cmd_q` bit 0 is set leaves `tx_buf` unchanged and sets `wr_coll`. A beat offered at any other time loads `tx_buf` on the next edge.
- R8: While `cmd_q` bit 0 is set, control writes are ignored. All five command bits keep their values, and the running sequence keeps its timing.
- R9: Status flags are sticky. `flag_clr` bit 0 clears `start_seen`, bit 1 clears `done_irq`, bit 2 clears `bus_coll` and bit 3 clears `wr_coll`. A set event in the same cycle wins over a clear.
- R10: After completion, a control write releases `sda_drive_low` on the next edge and stores all five written bits in `cmd_q`.
- R11: Bus inputs pass through two synchronizer flops. An SCL fall presented between edges E0+3 and E0+4 in a long first phase aborts the start at edge E0+6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Command register write strobe |
| ctl_wdata | input | 5 | Command bits; bit 0 is start enable |
| cmd_q | output | 5 | Current command bits |
| reload_wr | input | 1 | Reload register write strobe |
| reload_wdata | input | 7 | Baud counter reload value |
| tx_valid | input | 1 | Transmit beat valid |
| tx_ready | output | 1 | Transmit beat ready (always 1) |
| tx_data | input | 8 | Transmit beat data |
| tx_buf | output | 8 | Transmit buffer contents |
| flag_clr | input | 4 | Per-flag clear strobes |
| start_seen | output | 1 | START placed on the bus |
| done_irq | output | 1 | Start sequence complete |
| bus_coll | output | 1 | Bus collision during start |
| wr_coll | output | 1 | Transmit write during start |
| sda_in | input | 1 | Sampled data line |
| scl_in | input | 1 | Sampled clock line |
| sda_drive_low | output | 1 | Pull data line low |
| scl_drive_low | output | 1 | Pull clock line low |

## Verification
A wrong phase state or counter value shows first at `sda_drive_low` and `start_seen`. Either one moves off edge E0+R+2, which the bench checks every cycle for each reload value from 0 to 15 and for 127. An error in the second phase shows as a `done_irq` or `cmd_q` edge away from E0+2R+3. A broken lock or abort path shows within one cycle on `cmd_q`, `tx_buf` or `bus_coll`. A synchronizer with the wrong depth moves the SCL abort off the exact edge.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_HELD = 2'd3
  } start_state_t;

  localparam int FLAG_SEEN = 0;
  localparam int FLAG_DONE = 1;
  localparam int FLAG_BCOL = 2;
  localparam int FLAG_WCOL = 3;
  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], raw[g]};
      end
      assign synced[g] = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         stop,
  input  logic [W-1:0] reload,
  output logic         timeout
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= reload;
      run <= 1'b1;
    end else if (stop) begin
      run <= 1'b0;
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign timeout = run && (cnt == '0);
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_en,
  input  logic sda_hi,
  input  logic scl_hi,
  input  logic timeout,
  input  logic release_req,
  output logic cnt_load,
  output logic cnt_stop,
  output logic set_seen,
  output logic set_done,
  output logic set_coll,
  output logic clr_en,
  output logic sda_low
);
  start_state_t state, state_nxt;
  logic         sda_low_nxt;

  always_comb begin
    state_nxt   = state;
    sda_low_nxt = sda_low;
    cnt_load    = 1'b0;
    cnt_stop    = 1'b0;
    set_seen    = 1'b0;
    set_done    = 1'b0;
    set_coll    = 1'b0;
    clr_en      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        sda_low_nxt = 1'b0;
        if (start_en) begin
          if (sda_hi && scl_hi) begin
            cnt_load  = 1'b1;
            state_nxt = ST_PH1;
          end else begin
            set_coll = 1'b1;
            clr_en   = 1'b1;
          end
        end
      end
      ST_PH1: begin
        if (!scl_hi) begin
          set_coll  = 1'b1;
          clr_en    = 1'b1;
          cnt_stop  = 1'b1;
          state_nxt = ST_IDLE;
        end else if (timeout) begin
          if (sda_hi) begin
            cnt_load    = 1'b1;
            set_seen    = 1'b1;
            sda_low_nxt = 1'b1;
            state_nxt   = ST_PH2;
          end else begin
            set_coll  = 1'b1;
            clr_en    = 1'b1;
            cnt_stop  = 1'b1;
            state_nxt = ST_IDLE;
          end
        end
      end
      ST_PH2: begin
        if (timeout) begin
          cnt_stop  = 1'b1;
          set_done  = 1'b1;
          clr_en    = 1'b1;
          state_nxt = ST_HELD;
        end
      end
      ST_HELD: begin
        if (release_req) begin
          sda_low_nxt = 1'b0;
          state_nxt   = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sda_low <= 1'b0;
    end else begin
      state   <= state_nxt;
      sda_low <= sda_low_nxt;
    end
  end
endmodule

// File: rtl/i2c_start_regs.sv
module i2c_start_regs
  import i2c_start_pkg::*;
#(
  parameter int CMD_W    = 5,
  parameter int RELOAD_W = 7,
  parameter int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_wr,
  input  logic [CMD_W-1:0]     ctl_wdata,
  input  logic                 clr_en,
  input  logic                 reload_wr,
  input  logic [RELOAD_W-1:0]  reload_wdata,
  input  logic                 tx_valid,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 set_seen,
  input  logic                 set_done,
  input  logic                 set_coll,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic [CMD_W-1:0]     cmd_q,
  output logic [RELOAD_W-1:0]  reload_q,
  output logic [DATA_W-1:0]    tx_buf,
  output logic [NUM_FLAGS-1:0] flags
);
  logic                 busy;
  logic [NUM_FLAGS-1:0] set_vec;

  assign busy = cmd_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (ctl_wr && !busy) begin
      cmd_q <= ctl_wdata;
    end else if (clr_en) begin
      cmd_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            reload_q <= '0;
    else if (reload_wr) reload_q <= reload_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                   tx_buf <= '0;
    else if (tx_valid && !busy) tx_buf <= tx_data;
  end

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_SEEN] = set_seen;
    set_vec[FLAG_DONE] = set_done;
    set_vec[FLAG_BCOL] = set_coll;
    set_vec[FLAG_WCOL] = tx_valid && busy;
  end

  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) flags[f] <= 1'b0;
        else     flags[f] <= set_vec[f] | (flags[f] & ~flag_clr[f]);
      end
    end
  endgenerate
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int CMD_W       = 5,
  parameter int RELOAD_W    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_wr,
  input  logic [CMD_W-1:0]     ctl_wdata,
  output logic [CMD_W-1:0]     cmd_q,
  input  logic                 reload_wr,
  input  logic [RELOAD_W-1:0]  reload_wdata,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_W-1:0]    tx_data,
  output logic [DATA_W-1:0]    tx_buf,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic                 start_seen,
  output logic                 done_irq,
  output logic                 bus_coll,
  output logic                 wr_coll,
  input  logic                 sda_in,
  input  logic                 scl_in,
  output logic                 sda_drive_low,
  output logic                 scl_drive_low
);
  localparam int LINES = 2;

  logic [LINES-1:0]     lines_s;
  logic [RELOAD_W-1:0]  reload_q;
  logic [NUM_FLAGS-1:0] flags;
  logic cnt_load, cnt_stop, timeout;
  logic set_seen, set_done, set_coll, clr_en;

  i2c_line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw({scl_in, sda_in}), .synced(lines_s)
  );

  i2c_baud_cnt #(.W(RELOAD_W)) u_baud (
    .clk(clk), .rst(rst), .load(cnt_load), .stop(cnt_stop),
    .reload(reload_q), .timeout(timeout)
  );

  i2c_start_fsm u_fsm (
    .clk(clk), .rst(rst), .start_en(cmd_q[0]),
    .sda_hi(lines_s[0]), .scl_hi(lines_s[1]), .timeout(timeout),
    .release_req(ctl_wr), .cnt_load(cnt_load), .cnt_stop(cnt_stop),
    .set_seen(set_seen), .set_done(set_done), .set_coll(set_coll),
    .clr_en(clr_en), .sda_low(sda_drive_low)
  );

  i2c_start_regs #(.CMD_W(CMD_W), .RELOAD_W(RELOAD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .clr_en(clr_en), .reload_wr(reload_wr), .reload_wdata(reload_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .set_seen(set_seen),
    .set_done(set_done), .set_coll(set_coll), .flag_clr(flag_clr),
    .cmd_q(cmd_q), .reload_q(reload_q), .tx_buf(tx_buf), .flags(flags)
  );

  assign tx_ready      = 1'b1;
  assign scl_drive_low = 1'b0;
  assign start_seen    = flags[FLAG_SEEN];
  assign done_irq      = flags[FLAG_DONE];
  assign bus_coll      = flags[FLAG_BCOL];
  assign wr_coll       = flags[FLAG_WCOL];
endmodule

// File: rtl/i2c_start_chk.sv
module i2c_start_chk #(
  parameter int CMD_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_wr,
  input logic [CMD_W-1:0]  cmd_q,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_buf,
  input logic              start_seen,
  input logic              done_irq,
  input logic              bus_coll,
  input logic              wr_coll,
  input logic              sda_drive_low
);
  assert_start_flag_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> (start_seen && cmd_q[0]));

  assert_done_state_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq) |-> (sda_drive_low && !cmd_q[0]));

  assert_coll_abort_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_coll) |-> (!sda_drive_low && !cmd_q[0]));

  assert_tx_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[0] && tx_valid) |=> ($stable(tx_buf) && wr_coll));

  assert_cmd_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[0] && ctl_wr) |=> (cmd_q[CMD_W-1:1] == $past(cmd_q[CMD_W-1:1])));
endmodule

bind i2c_start_gen i2c_start_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .cmd_q(cmd_q), .tx_valid(tx_valid),
  .tx_buf(tx_buf), .start_seen(start_seen), .done_irq(done_irq),
  .bus_coll(bus_coll), .wr_coll(wr_coll), .sda_drive_low(sda_drive_low)
);

// File: tb/i2c_start_gen_tb_top.sv
module i2c_start_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] cmd_q;
  logic       reload_wr = 1'b0;
  logic [6:0] reload_wdata = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic [7:0] tx_buf;
  logic [3:0] flag_clr = '0;
  logic       start_seen, done_irq, bus_coll, wr_coll;
  logic       sda_drive_low, scl_drive_low;
  logic       ext_sda = 1'b1, ext_scl = 1'b1;
  logic       sda_in, scl_in;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_in = ext_sda & ~sda_drive_low;
  assign scl_in = ext_scl & ~scl_drive_low;

  i2c_start_gen dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cmd_q(cmd_q),
    .reload_wr(reload_wr), .reload_wdata(reload_wdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_buf(tx_buf), .flag_clr(flag_clr),
    .start_seen(start_seen), .done_irq(done_irq), .bus_coll(bus_coll),
    .wr_coll(wr_coll), .sda_in(sda_in), .scl_in(scl_in),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic cycle(); @(posedge clk); @(negedge clk); endtask

  task automatic set_reload(input int r);
    reload_wr = 1'b1; reload_wdata = 7'(r);
    cycle();
    reload_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic [4:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    cycle();
    ctl_wr = 1'b0;
  endtask

  task automatic clear_all();
    flag_clr = 4'hF;
    cycle();
    flag_clr = 4'h0;
    chk("R9 flags cleared", {start_seen, done_irq, bus_coll, wr_coll}, 0);
  endtask

  // Full start with per-cycle checks; k counts edges after the capture edge E0.
  task automatic run_start(input int r, input bit inject_lock);
    int last = 2*r + 5;
    set_reload(r);
    ctl_write(5'b00001);
    for (int k = 0; k <= last; k++) begin
      if (k > 0) cycle();
      if (inject_lock && k == 3) begin
        ctl_wr = 1'b0; tx_valid = 1'b0;
        chk("R8 locked cmd bits", cmd_q, 1);
        chk("R7 buffer unchanged", tx_buf, 8'hA5);
        chk("R7 write collision", wr_coll, 1);
      end
      chk($sformatf("R2 sda drive r=%0d k=%0d", r, k), sda_drive_low, (k >= r+2));
      chk($sformatf("R3 start seen r=%0d k=%0d", r, k), start_seen, (k >= r+2));
      chk($sformatf("R4 done r=%0d k=%0d", r, k), done_irq, (k >= 2*r+3));
      chk($sformatf("R4 enable r=%0d k=%0d", r, k), cmd_q[0], (k < 2*r+3));
      chk("R4 scl released", scl_drive_low, 0);
      chk("R6 no collision", bus_coll, 0);
      if (inject_lock && k == 2) begin
        ctl_wr = 1'b1; ctl_wdata = 5'b11110;
        tx_valid = 1'b1; tx_data = 8'h5A;
      end
    end
    ctl_write(5'b00000);
    chk("R10 sda released", sda_drive_low, 0);
    chk("R10 cmd stored", cmd_q, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 cmd", cmd_q, 0);
    chk("R1 tx_buf", tx_buf, 0);
    chk("R1 flags", {start_seen, done_irq, bus_coll, wr_coll}, 0);
    chk("R1 drives", {sda_drive_low, scl_drive_low}, 0);
    chk("R1 tx_ready", tx_ready, 1);

    tx_valid = 1'b1; tx_data = 8'hA5;
    cycle();
    tx_valid = 1'b0;
    chk("R7 idle write loads", tx_buf, 8'hA5);
    chk("R7 idle no collision", wr_coll, 0);

    for (int r = 0; r < 16; r++) run_start(r, 1'b0);
    run_start(127, 1'b0);
    run_start(6, 1'b1);
    clear_all();

    // R10: store all five bits after a completed start
    set_reload(1);
    ctl_write(5'b00001);
    repeat (6) cycle();
    chk("R4 hold before release", sda_drive_low, 1);
    ctl_write(5'b10100);
    chk("R10 bits stored", cmd_q, 5'b10100);
    chk("R10 sda released", sda_drive_low, 0);
    ctl_write(5'b00000);
    chk("R9 sticky done", done_irq, 1);
    clear_all();

    // R5: line already low at begin (SDA, SCL, both)
    for (int p = 1; p <= 3; p++) begin
      ext_sda = !(p[0]); ext_scl = !(p[1]);
      repeat (3) cycle();
      ctl_write(5'b00001);
      chk($sformatf("R5 enable k0 p=%0d", p), cmd_q[0], 1);
      cycle();
      chk($sformatf("R5 bus_coll p=%0d", p), bus_coll, 1);
      chk($sformatf("R5 enable cleared p=%0d", p), cmd_q[0], 0);
      chk($sformatf("R5 no sda p=%0d", p), sda_drive_low, 0);
      chk($sformatf("R5 no start p=%0d", p), start_seen, 0);
      ext_sda = 1'b1; ext_scl = 1'b1;
      repeat (3) cycle();
      clear_all();
    end

    // R6 / R11: SCL falls mid first phase
    set_reload(10);
    ctl_write(5'b00001);
    for (int k = 1; k <= 6; k++) begin
      cycle();
      if (k == 3) ext_scl = 1'b0;
      if (k == 5) chk("R11 no abort yet", bus_coll, 0);
      if (k == 6) begin
        chk("R11 abort edge", bus_coll, 1);
        chk("R6 enable cleared", cmd_q[0], 0);
        chk("R6 drives released", {sda_drive_low, scl_drive_low}, 0);
      end
    end
    ext_scl = 1'b1;
    repeat (3) cycle();
    clear_all();

    // R6: SDA low at first timeout
    set_reload(4);
    ctl_write(5'b00001);
    for (int k = 1; k <= 6; k++) begin
      cycle();
      if (k == 1) ext_sda = 1'b0;
      if (k == 5) chk("R6 still running", {bus_coll, cmd_q[0]}, 1);
      if (k == 6) begin
        chk("R6 timeout collision", bus_coll, 1);
        chk("R6 no start flag", start_seen, 0);
        chk("R6 enable off", cmd_q[0], 0);
        chk("R6 sda free", sda_drive_low, 0);
      end
    end
    ext_sda = 1'b1;
    repeat (3) cycle();

    // R9: set wins over clear in the same cycle
    tx_valid = 1'b1; tx_data = 8'h11;
    ctl_write(5'b00001);
    tx_valid = 1'b1; flag_clr = 4'h8;
    cycle();
    tx_valid = 1'b0; flag_clr = 4'h0;
    chk("R9 set wins", wr_coll, 1);
    repeat (12) cycle();
    ctl_write(5'b00000);
    clear_all();

    report();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end
endmodule